// File: doc/BRIEF.md
# Deferred Nonvolatile Commit Sequencer

This block owns the nonvolatile data registers of a quad digital potentiometer: four pots with four 8-bit registers each. It sits behind the serial front end. While chip select is low it receives a bit stream, one bit per SCK-rise strobe. The first byte is an instruction, and an optional second byte follows. Three kinds of write can change the registers. A host write stores a byte. A single transfer copies one pot's current wiper position into one of that pot's registers. A global transfer copies every pot's wiper position into the same register index for all pots.

A write is only armed while the frame is in progress. It takes effect on the clock where chip select is first seen high, and only if the frame carried every bit the command needs. A committed write starts a timed busy interval that stands in for the cell programming time, and a write-in-process flag is raised for that interval. While the flag is up, any write frame that closes is dropped. Register reads and the status read, which returns the flag, work at all times. The neighbouring wiper logic sees the register contents through a flat parallel output.

Top module: `nvws_seq`

## Requirements
- R1: After reset every data register reads 0, `wip` is low and `sdo_en` is low.
- R2: While `cs_n` is low, each cycle with `sck_rise` high shifts in `sdi`, MSB first. The first 8 bits are the instruction: bits 7:4 opcode, bits 3:2 register index, bits 1:0 pot. The next 8 bits are the data byte. Register r of pot p sits at `dr_flat[(p*4+r)*8 +: 8]`.
- R3: Opcode 4'hC (host write) needs 16 bits. In the cycle after `cs_n` is first sampled high, the addressed register holds the data byte.
- R4: Opcode 4'hE (single transfer) needs 8 bits. At the close of the frame, the addressed register takes `wiper_pos[p*8 +: 8]` of the addressed pot p.
- R5: Opcode 4'h8 (global transfer) needs 8 bits. In one commit, register index r of every pot takes that pot's wiper position. The pot field is ignored.
- R6: A write frame that closes with fewer bits than its opcode needs changes no register and leaves `wip` low.
- R7: A commit raises `wip` in the cycle after `cs_n` is sampled high. `wip` stays high for exactly BUSY_CYCLES cycles.
- R8: A write frame that closes while `wip` is high changes no register and does not extend the busy interval.
- R9: Opcode 4'hB (register read) drives the addressed register on `sdo`, MSB first, with `sdo_en` high, during bit slots 9 to 16 of the frame. Reads work while `wip` is high.
- R10: Opcode 4'h5 (status read) drives the byte {7'b0, wip} in the same bit slots.
- R11: Bits clocked in past bit 16 are ignored. The data byte of a host write is the byte that directly follows the instruction.
- R12: Any other opcode changes no register and leaves `wip` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| sck_rise | input | 1 | One-cycle strobe for each serial clock rise |
| sdi | input | 1 | Serial data in |
| wiper_pos | input | NPOT*DW | Current wiper position of each pot, pot 0 in the low byte |
| sdo | output | 1 | Serial read data |
| sdo_en | output | 1 | High while `sdo` carries read data |
| wip | output | 1 | Write-in-process flag |
| dr_flat | output | NPOT*NREG*DW | All data registers, flat |

## Verification
Host writes, single transfers and a global transfer are each committed to different register slots. A single misdirected index or a partial global copy therefore shows up in the flat output. Short frames cut in the instruction byte and in the data byte, together with an over-long frame, separate a bit-count check that is too loose or too strict. A write closed inside the busy window, and a read and a status read taken inside that window, separate rejection of writes from a wrong blocking of reads. A full count of the busy window pins its length to the cycle.

// File: rtl/nvws_pkg.sv
package nvws_pkg;
    localparam int NPOT     = 4;
    localparam int NREG     = 4;
    localparam int IW       = 8;
    localparam logic [3:0] OP_WRITE = 4'hC;
    localparam logic [3:0] OP_READ  = 4'hB;
    localparam logic [3:0] OP_STAT  = 4'h5;
    localparam logic [3:0] OP_XONE  = 4'hE;
    localparam logic [3:0] OP_XALL  = 4'h8;
endpackage

// File: rtl/nvws_frame.sv
module nvws_frame
    import nvws_pkg::*;
#(
    parameter int DW = 8,
    localparam int FMAX = IW + DW,
    localparam int CW = $clog2(FMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck_rise,
    input  logic          sdi,
    output logic          frame_end,
    output logic [CW-1:0] bit_cnt,
    output logic [IW-1:0] instr,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          csn;
        logic [CW-1:0] cnt;
        logic [IW-1:0] ins;
        logic [DW-1:0] shf;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.csn = cs_n;
        if (cs_n) begin
            st_d.cnt = '0;
        end else if (sck_rise && (st_q.cnt < CW'(FMAX))) begin
            if (st_q.cnt < CW'(IW))
                st_d.ins = {st_q.ins[IW-2:0], sdi};
            else
                st_d.shf = {st_q.shf[DW-2:0], sdi};
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{csn: 1'b1, cnt: '0, ins: '0, shf: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_end = cs_n & ~st_q.csn;
    assign bit_cnt   = st_q.cnt;
    assign instr     = st_q.ins;
    assign data      = st_q.shf;
endmodule

// File: rtl/nvws_busy.sv
module nvws_busy #(
    parameter int BUSY_CYCLES = 1_000_000,
    localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(BUSY_CYCLES - 1);
        end else if (st_q.busy) begin
            if (st_q.cnt == '0)
                st_d.busy = 1'b0;
            else
                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/nvws_seq.sv
module nvws_seq
    import nvws_pkg::*;
#(
    parameter int DW = 8,
    parameter int BUSY_CYCLES = 1_000_000,
    localparam int FMAX = IW + DW,
    localparam int CW = $clog2(FMAX + 1),
    localparam int NENT = NPOT * NREG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sck_rise,
    input  logic                 sdi,
    input  logic [NPOT*DW-1:0]   wiper_pos,
    output logic                 sdo,
    output logic                 sdo_en,
    output logic                 wip,
    output logic [NENT*DW-1:0]   dr_flat
);
    typedef struct packed {
        logic [NENT-1:0][DW-1:0] regs;
    } st_t;

    st_t st_d, st_q;

    logic          frame_end;
    logic [CW-1:0] bit_cnt;
    logic [IW-1:0] instr;
    logic [DW-1:0] data;
    logic          commit;

    nvws_frame #(.DW(DW)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck_rise  (sck_rise),
        .sdi       (sdi),
        .frame_end (frame_end),
        .bit_cnt   (bit_cnt),
        .instr     (instr),
        .data      (data)
    );

    nvws_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit),
        .busy  (wip)
    );

    logic [3:0] op;
    logic [1:0] rsel;
    logic [1:0] psel;
    logic       ins_done;
    logic       all_bits;
    logic       armed;
    logic [DW-1:0] rd_byte;

    assign op       = instr[7:4];
    assign rsel     = instr[3:2];
    assign psel     = instr[1:0];
    assign ins_done = bit_cnt >= CW'(IW);
    assign all_bits = bit_cnt == CW'(FMAX);

    always_comb begin
        unique case (op)
            OP_WRITE:         armed = all_bits;
            OP_XONE, OP_XALL: armed = ins_done;
            default:          armed = 1'b0;
        endcase
    end

    assign commit = frame_end & ~wip & armed;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            case (op)
                OP_WRITE: st_d.regs[int'(psel)*NREG + int'(rsel)] = data;
                OP_XONE:  st_d.regs[int'(psel)*NREG + int'(rsel)] =
                              wiper_pos[int'(psel)*DW +: DW];
                default: begin
                    for (int p = 0; p < NPOT; p++)
                        st_d.regs[p*NREG + int'(rsel)] = wiper_pos[p*DW +: DW];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (op == OP_STAT)
            rd_byte = {{(DW-1){1'b0}}, wip};
        else
            rd_byte = st_q.regs[int'(psel)*NREG + int'(rsel)];
        sdo_en = ~cs_n & ins_done & ~all_bits & ((op == OP_READ) | (op == OP_STAT));
        sdo    = 1'b0;
        if (sdo_en)
            sdo = rd_byte[DW - 1 - (int'(bit_cnt) - IW)];
    end

    assign dr_flat = st_q.regs;
endmodule

// File: rtl/nvws_seq_chk.sv
module nvws_seq_chk #(
    parameter int DW = 8,
    parameter int BUSY_CYCLES = 1_000_000,
    localparam int W = 16 * DW
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n,
    input logic         sdo_en,
    input logic         wip,
    input logic [W-1:0] dr_flat
);
    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   run_len <= 0;
        else if (wip) run_len <= run_len + 1;
        else          run_len <= 0;
    end

    AST_STORE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dr_flat) |-> $rose(wip)); // R3
    AST_BUSY_AFTER_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(cs_n)); // R7
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> run_len == BUSY_CYCLES); // R7
    AST_NO_STORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wip) |-> $stable(dr_flat)); // R8
    AST_READ_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_en |-> !cs_n); // R9
endmodule

bind nvws_seq nvws_seq_chk #(.DW(DW), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (.*);

// File: tb/nvws_seq_tb.sv
module nvws_seq_tb;
    localparam int BUSY = 200;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         sck_rise = 1'b0;
    logic         sdi = 1'b0;
    logic [31:0]  wiper_pos = '0;
    logic         sdo, sdo_en, wip;
    logic [127:0] dr_flat;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nvws_seq #(.DW(8), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise), .sdi(sdi),
        .wiper_pos(wiper_pos), .sdo(sdo), .sdo_en(sdo_en), .wip(wip), .dr_flat(dr_flat)
    );

    // behavioural reference
    int  mregs [16];
    int  mbusy, mbits, mins, mdat;
    bit  mprev_cs;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mregs[i]) mregs[i] = 0;
            mbusy = 0; mbits = 0; mins = 0; mdat = 0; mprev_cs = 1;
        end else begin
            bit ok;
            int opc, r, p;
            opc = mins >> 4; r = (mins >> 2) & 3; p = mins & 3;
            ok = 0;
            if (cs_n && !mprev_cs && mbusy == 0) begin
                if (opc == 12 && mbits == 16) begin mregs[p*4+r] = mdat; ok = 1; end
                if (opc == 14 && mbits >= 8) begin mregs[p*4+r] = (wiper_pos >> (8*p)) & 255; ok = 1; end
                if (opc == 8 && mbits >= 8) begin
                    for (int k = 0; k < 4; k++) mregs[k*4+r] = (wiper_pos >> (8*k)) & 255;
                    ok = 1;
                end
            end
            if (ok) mbusy = BUSY;
            else if (mbusy > 0) mbusy--;
            if (cs_n) mbits = 0;
            else if (sck_rise && mbits < 16) begin
                if (mbits < 8) mins = ((mins << 1) | sdi) & 255;
                else mdat = ((mdat << 1) | sdi) & 255;
                mbits++;
            end
            mprev_cs = cs_n;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int opc, val;
            bit en;
            opc = mins >> 4;
            for (int i = 0; i < 16; i++)
                check(dr_flat[i*8 +: 8] == 8'(mregs[i]), "R3 model register", dr_flat[i*8 +: 8], mregs[i]);
            check(wip == (mbusy > 0), "R7 model wip", wip, mbusy > 0);
            en = !cs_n && mbits >= 8 && mbits < 16 && (opc == 11 || opc == 5);
            check(sdo_en == en, "R9 model sdo_en", sdo_en, en);
            if (en) begin
                val = (opc == 5) ? (mbusy > 0) : mregs[(mins & 3)*4 + ((mins >> 2) & 3)];
                check(sdo == ((val >> (15 - mbits)) & 1), "R10 model sdo", sdo, (val >> (15 - mbits)) & 1);
            end
        end
    end

    function automatic int ent(input int idx);
        return int'(dr_flat[idx*8 +: 8]);
    endfunction

    task automatic send_bit(input bit b);
        @(negedge clk); sdi = b; sck_rise = 1'b1;
        @(negedge clk); sck_rise = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
    endtask

    task automatic open_frame();
        @(negedge clk); cs_n = 1'b0;
    endtask

    task automatic close_frame();
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_frame(input logic [7:0] ins, input logic [7:0] dat);
        open_frame(); send_bits(ins, 8); send_bits(dat, 8); close_frame();
    endtask

    task automatic rd_frame(input logic [7:0] ins, output logic [7:0] v);
        open_frame(); send_bits(ins, 8);
        for (int k = 7; k >= 0; k--) begin
            v[k] = sdo;
            send_bit(1'b0);
        end
        close_frame();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && wip; i++) @(negedge clk);
    endtask

    initial begin
        #(10 * 150000);
        $display("FAIL watchdog actual=running expected=finished");
        failures++;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(dr_flat == '0, "R1 regs", int'(dr_flat[31:0]), 0);
        check(!wip, "R1 wip", wip, 0);
        check(!sdo_en, "R1 sdo_en", sdo_en, 0);

        // R2 R3: pot1 reg2
        wr_frame(8'hC9, 8'hA5);
        check(ent(6) == 8'hA5, "R3 host write", ent(6), 8'hA5);
        check(wip, "R7 wip raised", wip, 1);
        // R8: write closed inside busy window
        wr_frame(8'hC0, 8'h3C);
        check(ent(0) == 0, "R8 busy write dropped", ent(0), 0);
        // R9 R10 during busy
        rd_frame(8'hB9, v);
        check(v == 8'hA5, "R9 read while busy", v, 8'hA5);
        rd_frame(8'h50, v);
        check(v == 8'h01, "R10 status busy", v, 1);
        wait_idle();
        check(ent(0) == 0, "R8 still dropped", ent(0), 0);
        rd_frame(8'h50, v);
        check(v == 8'h00, "R10 status idle", v, 0);

        // R7 busy length
        open_frame(); send_bits(8'hC0, 8); send_bits(8'h77, 8);
        @(negedge clk); cs_n = 1'b1;
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (wip) n++; else break;
        end
        check(n == BUSY, "R7 busy length", n, BUSY);
        check(ent(0) == 8'h77, "R3 pot0 reg0", ent(0), 8'h77);

        // R4 single transfer pot2 reg3
        wiper_pos = 32'h005E_0000;
        open_frame(); send_bits(8'hEE, 8); close_frame();
        check(ent(11) == 8'h5E, "R4 single transfer", ent(11), 8'h5E);
        wait_idle();

        // R5 global transfer reg1
        wiper_pos = 32'h4433_2211;
        open_frame(); send_bits(8'h84, 8); close_frame();
        check(ent(1) == 8'h11 && ent(5) == 8'h22, "R5 global low pots", ent(5), 8'h22);
        check(ent(9) == 8'h33 && ent(13) == 8'h44, "R5 global high pots", ent(13), 8'h44);
        check(wip, "R5 one commit busy", wip, 1);
        wait_idle();
        rd_frame(8'hB7, v);
        check(v == 8'h44, "R9 read pot3 reg1", v, 8'h44);

        // R6 incomplete frames
        open_frame(); send_bits(8'hC0, 8); send_bits(8'hFF, 4); close_frame();
        check(!wip && ent(0) == 8'h77, "R6 short write", ent(0), 8'h77);
        wiper_pos = 32'hFFFF_FFFF;
        open_frame(); send_bits(8'hEE, 5); close_frame();
        check(!wip && ent(11) == 8'h5E, "R6 short transfer", ent(11), 8'h5E);

        // R11 extra bits
        open_frame(); send_bits(8'hC4, 8); send_bits(8'h9A, 8); send_bits(8'hF0, 4); close_frame();
        check(ent(1) == 8'h9A, "R11 extra bits", ent(1), 8'h9A);
        wait_idle();

        // R12 unknown opcode
        wr_frame(8'h30, 8'hFF);
        check(!wip, "R12 no busy", wip, 0);
        check(ent(0) == 8'h77, "R12 no change", ent(0), 8'h77);

        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule